// File: doc/BRIEF.md
# Serial bus framing condition detector and generator

This block observes a two-wire synchronous serial bus made of one clock line and one shared, open-drain data line. Framing on this bus is carried by data transitions made while the clock is high. A rising data edge during clock-high marks a bus release. A falling data edge during clock-high marks a command. The block resynchronises both lines into the system clock domain and finds these conditions. It keeps a sticky flag for each one and records whether the byte that follows a command is an address or a command.

When the local device acts as bus master, it can also create either condition. A one-cycle request pulse arms a trigger bit. The generator waits for the bus clock to go low, sets up the data line, and waits for the clock to return high. It then makes the framing edge by pulling the data line low or letting it go, and clears the trigger when the sequence is complete. The data line is only ever pulled low: `sda_oe` high means "drive low", and low means "let the line float high". Shifting of data bytes is handled elsewhere.

Top module: `sbus_cond_det`

## Requirements
- R1: A rising edge on the data line, seen while the clock line is high in two consecutive synchronised samples, sets `rel_flag` and clears `cmd_flag`. The flags change on the third rising edge of `clk` after the data change.
- R2: A falling edge on the data line, seen while the clock line is high in two consecutive synchronised samples, sets `cmd_flag` and leaves `rel_flag` unchanged.
- R3: On every detected command, `byte_addr` takes the value `rel_flag` held just before the detection. 1 means the next byte is an address, because a release came before. 0 means the next byte is a command. `byte_addr` changes at no other time.
- R4: A one-cycle `flag_clr` clears `rel_flag` and `cmd_flag` on the next clock edge. A detection in the same cycle still sets its own flag. `flag_clr` does not alter `byte_addr`.
- R5: Data line changes made while the clock line is low, or while it is falling, leave both flags unchanged.
- R6: After reset, `rel_flag`, `cmd_flag`, `byte_addr`, `rel_trig`, `cmd_trig` and `sda_oe` are all 0.
- R7: A `rel_req` pulse sets `rel_trig`. The generator leaves the data line undriven until the clock line is seen low. It then drives data low, keeps driving it for `HOLD_CYC` cycles after the clock is seen high, and then lets it go for `HOLD_CYC` cycles, which makes a release edge. After that it clears `rel_trig`.
- R8: A `cmd_req` pulse sets `cmd_trig`. The generator waits for the clock line to be low and leaves data undriven while the clock rises and for `HOLD_CYC` cycles after. It then drives data low and holds it low until the clock line is seen low again. At that point it lets the line go and clears `cmd_trig`.
- R9: With no trigger pending, `sda_oe` is 0. When both triggers are pending, the release sequence is produced first and the command sequence after it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_in | input | 1 | Bus clock line, asynchronous |
| sda_in | input | 1 | Bus data line as seen on the wire, asynchronous |
| rel_req | input | 1 | One-cycle request to generate a release condition |
| cmd_req | input | 1 | One-cycle request to generate a command condition |
| flag_clr | input | 1 | One-cycle strobe clearing both detection flags |
| rel_flag | output | 1 | Release condition detected (sticky) |
| cmd_flag | output | 1 | Command condition detected (sticky) |
| byte_addr | output | 1 | 1: next byte is an address, 0: next byte is a command |
| rel_trig | output | 1 | Release generation pending |
| cmd_trig | output | 1 | Command generation pending |
| sda_oe | output | 1 | Pull the data line low when 1 |

## Verification
A faulty synchroniser or edge history would show up as flags that set one cycle too early or too late, or as flags that set for edges made while the clock was low. A per-cycle reference model catches these on the first cycle after the affected edge. A wrong flag interaction would show up as a wrong `byte_addr` on the first command after a release, or after a clear. A stuck or misordered generator state would show at `sda_oe` during the clock-low setup window, or as a trigger that never clears. This is visible within a few cycles of the bus clock changing.

// File: rtl/sbcd_pkg.sv
package sbcd_pkg;
  typedef enum logic [2:0] {
    G_IDLE,
    G_WAIT_LO,
    G_SETUP,
    G_FIRST,
    G_SECOND,
    G_TAIL
  } gen_state_e;
endpackage

// File: rtl/sbcd_sampler.sv
// Resynchronises the clock and data lines and flags framing edges.
module sbcd_sampler #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_in,
  input  logic sda_in,
  output logic scl_s,
  output logic rel_hit,
  output logic cmd_hit
);
  localparam int NL = 2;  // line 0: clock, line 1: data

  logic [NL-1:0] raw;
  logic [NL-1:0] cur;
  logic [NL-1:0] prv;

  assign raw = {sda_in, scl_in};

  for (genvar i = 0; i < NL; i++) begin : g_line
    logic [SYNC_STAGES-1:0] chain_q;
    logic                   prev_q;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        chain_q <= '0;
        prev_q  <= 1'b0;
      end else begin
        chain_q <= {chain_q[SYNC_STAGES-2:0], raw[i]};
        prev_q  <= chain_q[SYNC_STAGES-1];
      end
    end

    assign cur[i] = chain_q[SYNC_STAGES-1];
    assign prv[i] = prev_q;
  end

  logic clk_high;
  assign clk_high = cur[0] & prv[0];
  assign scl_s    = cur[0];
  assign rel_hit  = clk_high &  cur[1] & ~prv[1];
  assign cmd_hit  = clk_high & ~cur[1] &  prv[1];
endmodule

// File: rtl/sbcd_flags.sv
// Sticky condition flags and byte-type classification.
module sbcd_flags (
  input  logic clk,
  input  logic rst_n,
  input  logic rel_hit,
  input  logic cmd_hit,
  input  logic flag_clr,
  output logic rel_flag,
  output logic cmd_flag,
  output logic byte_addr
);
  logic rel_q, cmd_q, addr_q;
  logic rel_d, cmd_d, addr_d;
  logic upd_en;

  assign upd_en = rel_hit | cmd_hit | flag_clr;

  always_comb begin
    rel_d  = rel_q;
    cmd_d  = cmd_q;
    addr_d = addr_q;
    if (flag_clr) begin
      rel_d = 1'b0;
      cmd_d = 1'b0;
    end
    if (rel_hit) begin
      rel_d = 1'b1;
      cmd_d = 1'b0;
    end else if (cmd_hit) begin
      cmd_d  = 1'b1;
      addr_d = rel_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rel_q  <= 1'b0;
      cmd_q  <= 1'b0;
      addr_q <= 1'b0;
    end else if (upd_en) begin
      rel_q  <= rel_d;
      cmd_q  <= cmd_d;
      addr_q <= addr_d;
    end
  end

  assign rel_flag  = rel_q;
  assign cmd_flag  = cmd_q;
  assign byte_addr = addr_q;
endmodule

// File: rtl/sbcd_gen.sv
// Master-side generator for release and command conditions.
module sbcd_gen
  import sbcd_pkg::*;
#(
  parameter int HOLD_CYC = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_s,
  input  logic rel_req,
  input  logic cmd_req,
  output logic rel_trig,
  output logic cmd_trig,
  output logic sda_oe
);
  localparam int             CW   = (HOLD_CYC > 1) ? $clog2(HOLD_CYC) : 1;
  localparam logic [CW-1:0]  LAST = CW'(HOLD_CYC - 1);

  gen_state_e    st_q, st_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          sel_q, sel_d;     // 1: release sequence, 0: command sequence
  logic          rtrig_q, rtrig_d;
  logic          ctrig_q, ctrig_d;
  logic          rel_done, cmd_done;

  always_comb begin
    st_d     = st_q;
    cnt_d    = cnt_q;
    sel_d    = sel_q;
    rel_done = 1'b0;
    cmd_done = 1'b0;
    case (st_q)
      G_IDLE: begin
        if (rtrig_q | ctrig_q) begin
          sel_d = rtrig_q;
          st_d  = G_WAIT_LO;
        end
      end
      G_WAIT_LO: if (!scl_s) st_d = G_SETUP;
      G_SETUP: begin
        if (scl_s) begin
          st_d  = G_FIRST;
          cnt_d = '0;
        end
      end
      G_FIRST: begin
        if (cnt_q == LAST) begin
          st_d  = G_SECOND;
          cnt_d = '0;
        end else begin
          cnt_d = cnt_q + 1'b1;
        end
      end
      G_SECOND: begin
        if (cnt_q == LAST) begin
          if (sel_q) begin
            rel_done = 1'b1;
            st_d     = G_IDLE;
          end else begin
            st_d = G_TAIL;
          end
        end else begin
          cnt_d = cnt_q + 1'b1;
        end
      end
      G_TAIL: begin
        if (!scl_s) begin
          cmd_done = 1'b1;
          st_d     = G_IDLE;
        end
      end
      default: st_d = G_IDLE;
    endcase
    rtrig_d = rel_req | (rtrig_q & ~rel_done);
    ctrig_d = cmd_req | (ctrig_q & ~cmd_done);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= G_IDLE;
      cnt_q   <= '0;
      sel_q   <= 1'b0;
      rtrig_q <= 1'b0;
      ctrig_q <= 1'b0;
    end else begin
      st_q    <= st_d;
      cnt_q   <= cnt_d;
      sel_q   <= sel_d;
      rtrig_q <= rtrig_d;
      ctrig_q <= ctrig_d;
    end
  end

  always_comb begin
    sda_oe = 1'b0;
    if (sel_q && (st_q == G_SETUP || st_q == G_FIRST))   sda_oe = 1'b1;
    if (!sel_q && (st_q == G_SECOND || st_q == G_TAIL))  sda_oe = 1'b1;
  end

  assign rel_trig = rtrig_q;
  assign cmd_trig = ctrig_q;
endmodule

// File: rtl/sbus_cond_det.sv
// Top: reset synchroniser, line sampler, flag logic, condition generator.
module sbus_cond_det #(
  parameter int SYNC_STAGES = 2,
  parameter int HOLD_CYC    = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_in,
  input  logic sda_in,
  input  logic rel_req,
  input  logic cmd_req,
  input  logic flag_clr,
  output logic rel_flag,
  output logic cmd_flag,
  output logic byte_addr,
  output logic rel_trig,
  output logic cmd_trig,
  output logic sda_oe
);
  logic [1:0] rst_q;
  logic       rstn_s;
  logic       scl_s, rel_hit, cmd_hit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_q <= 2'b00;
    else        rst_q <= {rst_q[0], 1'b1};
  end
  assign rstn_s = rst_q[1];

  sbcd_sampler #(.SYNC_STAGES(SYNC_STAGES)) u_smp (
    .clk     (clk),
    .rst_n   (rstn_s),
    .scl_in  (scl_in),
    .sda_in  (sda_in),
    .scl_s   (scl_s),
    .rel_hit (rel_hit),
    .cmd_hit (cmd_hit)
  );

  sbcd_flags u_flg (
    .clk       (clk),
    .rst_n     (rstn_s),
    .rel_hit   (rel_hit),
    .cmd_hit   (cmd_hit),
    .flag_clr  (flag_clr),
    .rel_flag  (rel_flag),
    .cmd_flag  (cmd_flag),
    .byte_addr (byte_addr)
  );

  sbcd_gen #(.HOLD_CYC(HOLD_CYC)) u_gen (
    .clk      (clk),
    .rst_n    (rstn_s),
    .scl_s    (scl_s),
    .rel_req  (rel_req),
    .cmd_req  (cmd_req),
    .rel_trig (rel_trig),
    .cmd_trig (cmd_trig),
    .sda_oe   (sda_oe)
  );
endmodule

// File: rtl/sbcd_chk.sv
module sbcd_chk (
  input logic clk,
  input logic rstn_s,
  input logic rel_hit,
  input logic cmd_hit,
  input logic flag_clr,
  input logic rel_flag,
  input logic cmd_flag,
  input logic byte_addr,
  input logic rel_trig,
  input logic cmd_trig,
  input logic sda_oe
);
  AST_REL_SETS_CLEARS_CMD: assert property (@(posedge clk) disable iff (!rstn_s)
    rel_hit |=> (rel_flag && !cmd_flag));  // R1
  AST_CMD_SETS: assert property (@(posedge clk) disable iff (!rstn_s)
    (cmd_hit && !$past(1'b0)) |=> cmd_flag);  // R2
  AST_CMD_KEEPS_REL: assert property (@(posedge clk) disable iff (!rstn_s)
    (cmd_hit && rel_flag && !flag_clr) |=> rel_flag);  // R2
  AST_BYTE_TYPE: assert property (@(posedge clk) disable iff (!rstn_s)
    cmd_hit |=> (byte_addr == $past(rel_flag)));  // R3
  AST_BYTE_TYPE_HELD: assert property (@(posedge clk) disable iff (!rstn_s)
    !cmd_hit |=> $stable(byte_addr));  // R3
  AST_CLR_FLAGS: assert property (@(posedge clk) disable iff (!rstn_s)
    (flag_clr && !rel_hit && !cmd_hit) |=> (!rel_flag && !cmd_flag));  // R4
  AST_NO_DRIVE_IDLE: assert property (@(posedge clk) disable iff (!rstn_s)
    (!rel_trig && !cmd_trig) |-> !sda_oe);  // R9
endmodule

bind sbus_cond_det sbcd_chk u_chk (
  .clk       (clk),
  .rstn_s    (rstn_s),
  .rel_hit   (rel_hit),
  .cmd_hit   (cmd_hit),
  .flag_clr  (flag_clr),
  .rel_flag  (rel_flag),
  .cmd_flag  (cmd_flag),
  .byte_addr (byte_addr),
  .rel_trig  (rel_trig),
  .cmd_trig  (cmd_trig),
  .sda_oe    (sda_oe)
);

// File: tb/sbus_cond_det_bench.sv
`timescale 1ns/1ps
module sbus_cond_det_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scl_drv = 1'b1, sda_drv = 1'b1;
  logic rel_req = 1'b0, cmd_req = 1'b0, flag_clr = 1'b0;
  logic rel_flag, cmd_flag, byte_addr, rel_trig, cmd_trig, sda_oe;
  logic scl_line, sda_line;

  int n_chk = 0;
  int n_fail = 0;

  always #4 clk = ~clk;  // 125 MHz

  assign scl_line = scl_drv;
  assign sda_line = sda_oe ? 1'b0 : sda_drv;  // open-drain wire

  sbus_cond_det u_sbus_cond_det (
    .clk(clk), .rst_n(rst_n), .scl_in(scl_line), .sda_in(sda_line),
    .rel_req(rel_req), .cmd_req(cmd_req), .flag_clr(flag_clr),
    .rel_flag(rel_flag), .cmd_flag(cmd_flag), .byte_addr(byte_addr),
    .rel_trig(rel_trig), .cmd_trig(cmd_trig), .sda_oe(sda_oe)
  );

  task automatic chk(input logic act, input logic exp, input string what);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0b expected=%0b at %0t", what, act, exp, $time);
    end
  endtask

  // Behavioural reference for the flags: a history of pin samples.
  bit qscl[$];
  bit qsda[$];
  bit m_rel, m_cmd, m_addr;
  int rcnt;

  always @(negedge clk) begin
    if (!rst_n) begin
      m_rel = 0; m_cmd = 0; m_addr = 0; rcnt = 0;
      qscl = {0, 0, 0, 0};
      qsda = {0, 0, 0, 0};
    end else begin
      chk(rel_flag,  m_rel,  "R1 R4 model rel_flag");
      chk(cmd_flag,  m_cmd,  "R2 R4 R5 model cmd_flag");
      chk(byte_addr, m_addr, "R3 model byte_addr");
      if (rcnt < 2) begin
        rcnt++;
        qscl.push_back(0);
        qsda.push_back(0);
      end else begin
        bit rise, fall, old_rel;
        qscl.push_back(scl_line);
        qsda.push_back(sda_line);
        if (qscl.size() > 8) begin
          void'(qscl.pop_front());
          void'(qsda.pop_front());
        end
        rise = qsda[$-2] && !qsda[$-3] && qscl[$-2] && qscl[$-3];
        fall = !qsda[$-2] && qsda[$-3] && qscl[$-2] && qscl[$-3];
        old_rel = m_rel;
        if (flag_clr) begin m_rel = 0; m_cmd = 0; end
        if (rise) begin m_rel = 1; m_cmd = 0; end
        else if (fall) begin m_cmd = 1; m_addr = old_rel; end
      end
    end
  end

  task automatic step(input int n);
    repeat (n) @(posedge clk);
    #2;
  endtask

  task automatic bus(input logic c, input logic d, input int n);
    scl_drv = c; sda_drv = d;
    step(n);
  endtask

  task automatic clr_pulse();
    flag_clr = 1'b1; step(1); flag_clr = 1'b0; step(1);
  endtask

  initial begin : watchdog
    #1600000;
    n_fail++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    step(3);
    rst_n = 1'b1;
    step(4);
    // R6 reset state
    chk(rel_flag, 0, "R6 rel_flag after reset");
    chk(cmd_flag, 0, "R6 cmd_flag after reset");
    chk(byte_addr, 0, "R6 byte_addr after reset");
    chk(rel_trig | cmd_trig, 0, "R6 triggers after reset");
    chk(sda_oe, 0, "R6 sda_oe after reset");

    // R1 external release: data rises while clock high
    bus(0, 0, 4); bus(1, 0, 4); bus(1, 1, 5);
    chk(rel_flag, 1, "R1 release sets rel_flag");
    // R2 R3 command after release -> address
    bus(1, 0, 5);
    chk(cmd_flag, 1, "R2 command sets cmd_flag");
    chk(rel_flag, 1, "R2 rel_flag kept on command");
    chk(byte_addr, 1, "R3 byte after release is address");
    // R1 release clears command flag
    bus(1, 1, 5);
    chk(cmd_flag, 0, "R1 release clears cmd_flag");
    // R4 clear keeps byte_addr
    clr_pulse();
    chk(rel_flag, 0, "R4 clear rel_flag");
    chk(byte_addr, 1, "R4 clear leaves byte_addr");
    // R5 data edges with clock low
    bus(0, 1, 3); bus(0, 0, 3); bus(0, 1, 3); bus(0, 0, 3);
    chk(rel_flag | cmd_flag, 0, "R5 data edges while clock low");
    // R5 data rise together with clock fall
    bus(1, 0, 4); bus(0, 1, 5);
    chk(rel_flag, 0, "R5 data rise at clock fall");
    // R3 command with no prior release -> command byte
    bus(1, 1, 4); bus(1, 0, 5);
    chk(cmd_flag, 1, "R2 command alone");
    chk(byte_addr, 0, "R3 byte without release is command");
    bus(0, 1, 3); bus(1, 1, 3);
    clr_pulse();

    // R7 generated release
    rel_req = 1'b1; step(1); rel_req = 1'b0;
    chk(rel_trig, 1, "R7 rel_req arms rel_trig");
    step(4);
    chk(sda_oe, 0, "R7 no drive while clock high before setup");
    bus(0, 1, 5);
    chk(sda_oe, 1, "R7 data driven low in setup");
    bus(1, 1, 12);
    chk(rel_trig, 0, "R7 rel_trig cleared");
    chk(sda_oe, 0, "R7 data released");
    chk(rel_flag, 1, "R7 generated release detected");

    // R8 generated command
    cmd_req = 1'b1; step(1); cmd_req = 1'b0;
    chk(cmd_trig, 1, "R8 cmd_req arms cmd_trig");
    bus(0, 1, 5);
    chk(sda_oe, 0, "R8 data high in setup");
    bus(1, 1, 4);
    chk(sda_oe, 0, "R8 data high in first phase");
    step(10);
    chk(sda_oe, 1, "R8 data held low until clock low");
    chk(cmd_trig, 1, "R8 cmd_trig pending in tail");
    chk(cmd_flag, 1, "R8 generated command detected");
    chk(byte_addr, 1, "R3 generated command after release is address");
    bus(0, 1, 5);
    chk(sda_oe, 0, "R8 data released after clock low");
    chk(cmd_trig, 0, "R8 cmd_trig cleared");
    bus(1, 1, 4);
    clr_pulse();

    // R9 both requested: release first
    rel_req = 1'b1; cmd_req = 1'b1; step(1); rel_req = 1'b0; cmd_req = 1'b0;
    bus(0, 1, 5);
    chk(sda_oe, 1, "R9 release sequence served first");
    bus(1, 1, 12);
    chk(rel_flag, 1, "R9 release produced first");
    chk(cmd_flag, 0, "R9 command not yet produced");
    chk(rel_trig, 0, "R9 rel_trig cleared");
    chk(cmd_trig, 1, "R9 cmd_trig still pending");
    bus(0, 1, 5); bus(1, 1, 12);
    chk(cmd_flag, 1, "R9 command produced second");
    chk(byte_addr, 1, "R9 R3 address after generated release");
    bus(0, 1, 5);
    chk(cmd_trig, 0, "R9 cmd_trig cleared");
    chk(sda_oe, 0, "R9 no drive when idle");
    bus(1, 1, 4);

    // Random bus activity against the reference model
    for (int i = 0; i < 3000; i++) begin
      scl_drv  = ($urandom_range(0, 3) != 0) ? ~scl_drv : scl_drv;
      sda_drv  = ($urandom_range(0, 2) == 0) ? ~sda_drv : sda_drv;
      flag_clr = ($urandom_range(0, 15) == 0);
      step($urandom_range(1, 4));
    end
    flag_clr = 1'b0;
    step(6);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule